// File: doc/BRIEF.md
# Bridge Control Register Bank

This block holds the configuration words of a host bridge: 28 words of 32 bits each, at byte offsets 0x00 through 0x6C from the register base. A single request port carries reads and writes. Only full-word, word-aligned accesses take effect. All words are also driven onto a flat output bus, so the logic that uses the settings can read them directly.

The words are mostly plain storage. The exceptions are these:
- The interrupt-enable word can only be changed through a set port and a clear port.
- The enable word and the interrupt-status word ignore writes.
- The status word follows an input vector.
- One bit in the general-configuration word requests a system reset when a write takes it from 0 to 1.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset, these words hold the values shown; every other word reads 0.

  | Offset | Reset value |
  |---|---|
  | 0x00 | 0x00000C40 |
  | 0x04 | 0x00001384 |
  | 0x08 | 0x2BFF8010 |
  | 0x0C | 0x255E0091 |
  | 0x10 | 0x00006140 |
  | 0x1C | 0x000001FF |
  | 0x20 | 0x000001FF |
  | 0x68 | 0x00000008 |
  | 0x6C | 0x10000000 |

- R2: Every word from 0x00 to 0x6C, except 0x38 and 0x3C, stores the full 32-bit value of a valid write and returns it on a later read.
- R3: A valid write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38 in the same cycle.
- R4: A valid write to offset 0x34 stores the value at 0x34 and clears the bits of the enable word at 0x38 that are 1 in the written value.
- R5: Writes to 0x38 and 0x3C have no effect. The word at 0x3C captures int_status_i on every clock.
- R6: A valid write to 0x04 whose data bit 2 is 1, while the stored bit 2 is 0, makes sys_rst_req_o high for exactly the one cycle after the write edge. The written value is still stored. Writes that leave bit 2 at 1, or clear it, produce no pulse.
- R7: Offsets 0x70 to the top of the address space are undefined. Writes to them are ignored and reads return 0.
- R8: An access is valid only when be_i is 4'hF and addr_i[1:0] is 0. An invalid write changes nothing, and an invalid read returns 0.
- R9: rdata_o is loaded at the clock edge that samples a read request (req_i=1, we_i=0). It holds its value while no read is requested.
- R10: cfg_o bits [32k+31:32k] always show the word at offset 4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the bank |
| be_i | input | 4 | Byte enables; only 4'hF is valid |
| wdata_i | input | 32 | Write data |
| int_status_i | input | 32 | Interrupt status vector sampled into offset 0x3C |
| rdata_o | output | 32 | Registered read data |
| cfg_o | output | NUM_WORDS*32 | All words, flattened |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The following are checked by assertions on every cycle:
- the enable word gains the set bits after a write to 0x30;
- it loses the cleared bits after a write to 0x34;
- it holds still when neither port is written;
- the reset request never lasts longer than one cycle and always follows a write to 0x04;
- a miss read always returns zero.

Other behaviours only the directed scenarios can show:
- the reset values;
- storage at every plain offset;
- status capture;
- the absence of a pulse on a 1-to-1 write;
- that undefined or partial accesses leave every word untouched.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IDX_GEN   = 1;
  localparam int unsigned IDX_ENSET = 12;
  localparam int unsigned IDX_ENCLR = 13;
  localparam int unsigned IDX_EN    = 14;
  localparam int unsigned IDX_STAT  = 15;
  localparam int unsigned RST_BIT   = 2;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t reset_value(input int unsigned k);
    case (k)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/brb_decode.sv
module brb_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-3:0] word_addr;

  assign word_addr = addr_i[ADDR_W-1:2];
  assign idx_o     = word_addr[IDX_W-1:0];
  assign hit_o     = req_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00) &&
                     (32'(word_addr) < NUM_WORDS);

  always_comb begin
    if (hit_o) a_idx_in_range_r7 : assert (32'(idx_o) < NUM_WORDS);
  end
endmodule

// File: rtl/brb_intr_en.sv
module brb_intr_en
  import brb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_we_i,
  input  logic  clr_we_i,
  input  word_t wdata_i,
  output word_t en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= '0;
    else if (set_we_i) en_o <= en_o | wdata_i;
    else if (clr_we_i) en_o <= en_o & ~wdata_i;
  end

  p_set_ors_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

  p_clr_clears_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((en_o & $past(wdata_i)) == '0));

  p_en_stable_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(en_o));
endmodule

// File: rtl/brb_rst_req.sv
module brb_rst_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_we_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= gen_we_i && !old_bit_i && new_bit_i;
  end

  p_single_pulse_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_pulse_cause_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(gen_we_i));
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import brb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned CFG_W    = NUM_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       int_status_i,
  output logic [31:0]       rdata_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              sys_rst_req_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             wr_hit, rd_req;
  word_t            en_q;

  brb_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .req_i (req_i),
    .addr_i(addr_i),
    .be_i  (be_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  assign wr_hit = hit && we_i;
  assign rd_req = req_i && !we_i;

  brb_intr_en u_intr_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(wr_hit && (32'(idx) == IDX_ENSET)),
    .clr_we_i(wr_hit && (32'(idx) == IDX_ENCLR)),
    .wdata_i (wdata_i),
    .en_o    (en_q)
  );

  brb_rst_req u_rst_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gen_we_i (wr_hit && (32'(idx) == IDX_GEN)),
    .old_bit_i(cfg_o[IDX_GEN*WORD_W + RST_BIT]),
    .new_bit_i(wdata_i[RST_BIT]),
    .pulse_o  (sys_rst_req_o)
  );

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    word_t q;
    if (k == IDX_EN) begin : g_en
      assign q = en_q;
    end else if (k == IDX_STAT) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= int_status_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= reset_value(k);
        else if (wr_hit && (32'(idx) == k))   q <= wdata_i;
      end
    end
    assign cfg_o[k*WORD_W +: WORD_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_req) rdata_o <= hit ? cfg_o[32'(idx)*WORD_W +: WORD_W] : '0;
  end

  p_miss_read_zero_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !hit) |=> (rdata_o == '0));

  p_rdata_hold_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));
endmodule

// File: tb/sim_bridge_ctrl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctrl_regs;
  localparam int unsigned NW = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   wdata_i = '0, int_status_i = '0;
  logic [31:0]   rdata_o;
  logic [NW*32-1:0] cfg_o;
  logic          sys_rst_req_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bridge_ctrl_regs u0 (.*);

  function automatic logic [31:0] exp_reset(input int k);
    case (k)
      0: return 32'h0000_0C40;   1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;   3: return 32'h255E_0091;
      4: return 32'h0000_6140;   7: return 32'h0000_01FF;
      8: return 32'h0000_01FF;  26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; be_i = be;
    @(negedge clk_i);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  function automatic logic [31:0] cfg_word(input int k);
    return cfg_o[k*32 +: 32];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int k = 0; k < NW; k++) begin
      check("R1 reset cfg", cfg_word(k), exp_reset(k));
      rd(8'(k*4), d);
      check("R1 reset read", d, exp_reset(k));
    end
    check("R6 no pulse after reset", 32'(sys_rst_req_o), 32'h0);
  endtask

  task automatic t_plain_rw();
    logic [31:0] d, pat;
    for (int k = 0; k < NW; k++) begin
      if (k == 1 || (k >= 12 && k <= 15)) continue;
      pat = (32'(k) * 32'h0101_0101) ^ 32'h5A5A_5A5A;
      wr(8'(k*4), pat);
      check("R10 cfg slice", cfg_word(k), pat);
      rd(8'(k*4), d);
      check("R2 readback", d, pat);
    end
    rd(8'h08, d);
    @(negedge clk_i); @(negedge clk_i);
    check("R9 rdata holds", rdata_o, d);
  endtask

  task automatic t_int_en();
    logic [31:0] d;
    wr(8'h30, 32'h0000_00F0);
    check("R3 enable after set", cfg_word(14), 32'h0000_00F0);
    wr(8'h30, 32'h0000_0F00);
    check("R3 enable ored", cfg_word(14), 32'h0000_0FF0);
    rd(8'h30, d);
    check("R3 set word stored", d, 32'h0000_0F00);
    wr(8'h34, 32'h0000_0030);
    rd(8'h38, d);
    check("R4 enable cleared", d, 32'h0000_0FC0);
    rd(8'h34, d);
    check("R4 clr word stored", d, 32'h0000_0030);
    wr(8'h38, 32'hFFFF_FFFF);
    check("R5 enable ignores write", cfg_word(14), 32'h0000_0FC0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    int_status_i = 32'hA5A5_0001;
    @(negedge clk_i); @(negedge clk_i);
    wr(8'h3C, 32'h0000_0000);
    rd(8'h3C, d);
    check("R5 status follows input", d, 32'hA5A5_0001);
    int_status_i = 32'h0000_0000;
    @(negedge clk_i);
    check("R5 status cfg", cfg_word(15), 32'h0);
  endtask

  task automatic t_rst_req();
    wr(8'h04, 32'h0000_1380);
    check("R6 no pulse on clear", 32'(sys_rst_req_o), 32'h0);
    wr(8'h04, 32'h0000_1384);
    check("R6 pulse on rise", 32'(sys_rst_req_o), 32'h1);
    check("R6 value stored", cfg_word(1), 32'h0000_1384);
    @(negedge clk_i);
    check("R6 pulse one cycle", 32'(sys_rst_req_o), 32'h0);
    wr(8'h04, 32'h0000_0004);
    check("R6 no pulse 1->1", 32'(sys_rst_req_o), 32'h0);
  endtask

  task automatic t_undef();
    logic [NW*32-1:0] snap;
    logic [31:0] d;
    snap = cfg_o;
    wr(8'h70, 32'hDEAD_BEEF);
    wr(8'hFC, 32'hDEAD_BEEF);
    checks++;
    if (cfg_o !== snap) begin
      errors++;
      $display("FAIL R7 undefined write changed state: actual %h expected %h", cfg_o, snap);
    end
    rd(8'h70, d);
    check("R7 undefined read 0x70", d, 32'h0);
    rd(8'hFC, d);
    check("R7 undefined read 0xFC", d, 32'h0);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    wr(8'h40, 32'h1234_5678);
    wr(8'h40, 32'hFFFF_FFFF, 4'h3);
    check("R8 partial write ignored", cfg_word(16), 32'h1234_5678);
    wr(8'h42, 32'hFFFF_FFFF);
    check("R8 misaligned write ignored", cfg_word(16), 32'h1234_5678);
    rd(8'h40, d, 4'h3);
    check("R8 partial read zero", d, 32'h0);
    rd(8'h41, d);
    check("R8 misaligned read zero", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain_rw();
    t_int_en();
    t_status();
    t_rst_req();
    t_undef();
    t_partial();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule